// File: doc/BRIEF.md
# TLB Refill Register Port

This block is the maintenance port that privileged software uses to load translation entries. It holds the entry storage for two translation banks: an instruction bank and a data bank. Software first writes a selector register to pick a way and a set. It then writes a high word, which lands in the cause register. Finally it writes a low word, and that write commits the whole entry, using the low word it carries and the high word currently held in the cause register. Every register write carries a bank-select code. Only two code values reach the storage.

On each commit, the block returns the page-aligned virtual address that was held in the overwritten entry, with a one-cycle valid pulse, so that a downstream translation cache can drop its stale copy. The lookup side updates the cause register through its own fault-update input. A software write to the high register in the same cycle takes priority over that update. A combinational read port exposes the stored entries to the lookup logic.

Top module: `tlb_refill_port`

## Requirements
- R1: After an asynchronous reset, the selector and cause registers read zero, every stored high and low word in both banks reads zero, and `flush_valid_o` is low.
- R2: A write with register code 0 loads `wr_data_i[5:0]` into the selector one cycle later, whatever the bank-select value. Bits [3:0] are the set index and bits [5:4] are the way.
- R3: A write with register code 1 and bank-select 1 or 2 makes `cause_o` equal to the written data one cycle later.
- R4: A write with register code 2 and bank-select 1 or 2 stores the entry, with the high word taken from the cause register value before the edge and the low word from `wr_data_i`. The entry goes into the way and set named by the selector. Bank-select 1 targets the instruction bank (read bank 0) and bank-select 2 targets the data bank (read bank 1). The entry is readable on the read port after that edge.
- R5: A high or low register write whose bank-select value is neither 1 nor 2 changes neither the cause register nor any entry, and raises no flush.
- R6: In the cycle after each commit, `flush_valid_o` is high for exactly that cycle, and `flush_addr_o` holds bits [31:13] of the replaced entry's previous high word, shifted left by 13. With no commit, `flush_valid_o` is low.
- R7: When `fault_we_i` is high, the cause register loads `fault_cause_i`, unless a qualifying software high-register write happens in the same cycle. In that case the software data wins.
- R8: A commit changes only the addressed entry of the addressed bank. The same way and set in the other bank keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_reg_i | input | 2 | Register code: 0 selector, 1 high, 2 low, 3 none |
| wr_data_i | input | 32 | Write data |
| bank_sel_i | input | 4 | Bank-select value; 1 instruction, 2 data |
| fault_we_i | input | 1 | Lookup-side cause update strobe |
| fault_cause_i | input | 32 | Lookup-side cause value |
| rd_bank_i | input | 1 | Read bank: 0 instruction, 1 data |
| rd_way_i | input | 2 | Read way |
| rd_set_i | input | 4 | Read set |
| rd_hi_o | output | 32 | Stored high word at read address |
| rd_lo_o | output | 32 | Stored low word at read address |
| sel_o | output | 6 | Selector register |
| cause_o | output | 32 | Cause register |
| flush_valid_o | output | 1 | One-cycle flush pulse after a commit |
| flush_addr_o | output | 32 | Page address of the replaced entry |

## Verification
The bench builds the block with its default parameters: 16 sets, 4 ways, 32-bit words and a 13-bit page offset. With these values it can reach every way code, the top set index 15 and all of the page-number bits in the flush address. It overwrites an entry that is already populated, so the reported flush address is non-zero and comes visibly from the old contents. It drives fault updates alone, together with a high write, together with a rejected high write, and together with a low-word commit, which shows which cause value each of those cases stores.

// File: rtl/tlbrf_pkg.sv
package tlbrf_pkg;
  typedef enum logic [1:0] {
    REG_SEL  = 2'd0,
    REG_HI   = 2'd1,
    REG_LO   = 2'd2,
    REG_NONE = 2'd3
  } reg_code_e;

  localparam int BANK_CNT = 2;
endpackage

// File: rtl/tlbrf_decode.sv
module tlbrf_decode #(
  parameter int BANK_W     = 4,
  parameter int BANK_INSTR = 1,
  parameter int BANK_DATA  = 2
) (
  input  logic              wr_en_i,
  input  logic [1:0]        wr_reg_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  output logic              sel_we_o,
  output logic              hi_we_o,
  output logic              lo_we_o,
  output logic              bank_idx_o
);
  import tlbrf_pkg::*;

  logic bank_ok;

  always_comb begin
    bank_ok    = (bank_sel_i == BANK_W'(BANK_INSTR)) || (bank_sel_i == BANK_W'(BANK_DATA));
    bank_idx_o = (bank_sel_i == BANK_W'(BANK_DATA));
    sel_we_o   = wr_en_i && (wr_reg_i == REG_SEL);
    hi_we_o    = wr_en_i && (wr_reg_i == REG_HI) && bank_ok;
    lo_we_o    = wr_en_i && (wr_reg_i == REG_LO) && bank_ok;
  end
endmodule

// File: rtl/tlbrf_regs.sv
module tlbrf_regs #(
  parameter int DW    = 32,
  parameter int SEL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_data_i,
  input  logic             hi_we_i,
  input  logic [DW-1:0]    hi_data_i,
  input  logic             fault_we_i,
  input  logic [DW-1:0]    fault_cause_i,
  output logic [SEL_W-1:0] sel_q_o,
  output logic [DW-1:0]    cause_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q_o <= '0;
    end else if (sel_we_i) begin
      sel_q_o <= sel_data_i;
    end
  end

  // software high write outranks lookup-side update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q_o <= '0;
    end else if (hi_we_i) begin
      cause_q_o <= hi_data_i;
    end else if (fault_we_i) begin
      cause_q_o <= fault_cause_i;
    end
  end
endmodule

// File: rtl/tlbrf_array.sv
module tlbrf_array #(
  parameter int DW    = 32,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int N     = SETS * WAYS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wbank_i,
  input  logic [WAY_W-1:0] wway_i,
  input  logic [SET_W-1:0] wset_i,
  input  logic [DW-1:0]    whi_i,
  input  logic [DW-1:0]    wlo_i,
  output logic [DW-1:0]    old_hi_o,
  input  logic             rbank_i,
  input  logic [WAY_W-1:0] rway_i,
  input  logic [SET_W-1:0] rset_i,
  output logic [DW-1:0]    rhi_o,
  output logic [DW-1:0]    rlo_o
);
  import tlbrf_pkg::*;

  logic [WAY_W+SET_W-1:0] widx, ridx;
  logic [DW-1:0] rhi_b [BANK_CNT];
  logic [DW-1:0] rlo_b [BANK_CNT];
  logic [DW-1:0] ohi_b [BANK_CNT];

  assign widx = {wway_i, wset_i};
  assign ridx = {rway_i, rset_i};

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic [DW-1:0] hi_m [N];
    logic [DW-1:0] lo_m [N];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < N; i++) begin
          hi_m[i] <= '0;
          lo_m[i] <= '0;
        end
      end else if (we_i && (wbank_i == 1'(b))) begin
        hi_m[widx] <= whi_i;
        lo_m[widx] <= wlo_i;
      end
    end

    assign rhi_b[b] = hi_m[ridx];
    assign rlo_b[b] = lo_m[ridx];
    assign ohi_b[b] = hi_m[widx];
  end

  assign rhi_o    = rhi_b[rbank_i];
  assign rlo_o    = rlo_b[rbank_i];
  assign old_hi_o = ohi_b[wbank_i];
endmodule

// File: rtl/tlbrf_flush.sv
module tlbrf_flush #(
  parameter int DW         = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic [DW-1:PAGE_SHIFT] old_vpn_i,
  output logic                 valid_o,
  output logic [DW-1:0]        addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= commit_i;
      if (commit_i) addr_o <= {old_vpn_i, {PAGE_SHIFT{1'b0}}};
    end
  end
endmodule

// File: rtl/tlb_refill_port.sv
module tlb_refill_port #(
  parameter int DW         = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int PAGE_SHIFT = 13,
  parameter int BANK_W     = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int SEL_W = SET_W + WAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_reg_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              fault_we_i,
  input  logic [DW-1:0]     fault_cause_i,
  input  logic              rd_bank_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [SET_W-1:0]  rd_set_i,
  output logic [DW-1:0]     rd_hi_o,
  output logic [DW-1:0]     rd_lo_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DW-1:0]     cause_o,
  output logic              flush_valid_o,
  output logic [DW-1:0]     flush_addr_o
);
  import tlbrf_pkg::*;

  logic          sel_we, hi_we, lo_we, bank_idx;
  logic [DW-1:0] old_hi;

  tlbrf_decode #(.BANK_W(BANK_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_reg_i  (wr_reg_i),
    .bank_sel_i(bank_sel_i),
    .sel_we_o  (sel_we),
    .hi_we_o   (hi_we),
    .lo_we_o   (lo_we),
    .bank_idx_o(bank_idx)
  );

  tlbrf_regs #(.DW(DW), .SEL_W(SEL_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_we_i     (sel_we),
    .sel_data_i   (wr_data_i[SEL_W-1:0]),
    .hi_we_i      (hi_we),
    .hi_data_i    (wr_data_i),
    .fault_we_i   (fault_we_i),
    .fault_cause_i(fault_cause_i),
    .sel_q_o      (sel_o),
    .cause_q_o    (cause_o)
  );

  tlbrf_array #(.DW(DW), .SETS(SETS), .WAYS(WAYS)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lo_we),
    .wbank_i (bank_idx),
    .wway_i  (sel_o[SEL_W-1:SET_W]),
    .wset_i  (sel_o[SET_W-1:0]),
    .whi_i   (cause_o),
    .wlo_i   (wr_data_i),
    .old_hi_o(old_hi),
    .rbank_i (rd_bank_i),
    .rway_i  (rd_way_i),
    .rset_i  (rd_set_i),
    .rhi_o   (rd_hi_o),
    .rlo_o   (rd_lo_o)
  );

  tlbrf_flush #(.DW(DW), .PAGE_SHIFT(PAGE_SHIFT)) u_flush (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (lo_we),
    .old_vpn_i(old_hi[DW-1:PAGE_SHIFT]),
    .valid_o  (flush_valid_o),
    .addr_o   (flush_addr_o)
  );

  logic bank_good;
  assign bank_good = (bank_sel_i == BANK_W'(1)) || (bank_sel_i == BANK_W'(2));

  assert_sel_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_reg_i == REG_SEL) |=> (sel_o == $past(wr_data_i[SEL_W-1:0])));

  assert_hi_mirror_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_reg_i == REG_HI && bank_good) |=> (cause_o == $past(wr_data_i)));

  assert_fault_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_we_i && !(wr_en_i && wr_reg_i == REG_HI && bank_good)) |=> (cause_o == $past(fault_cause_i)));

  assert_bad_bank_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_reg_i == REG_HI && !bank_good && !fault_we_i) |=> $stable(cause_o));

  assert_flush_on_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_reg_i == REG_LO && bank_good) |=> flush_valid_o);

  assert_no_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_reg_i == REG_LO && bank_good) |=> !flush_valid_o);
endmodule

// File: tb/tlb_refill_port_test.sv
`timescale 1ns/1ps
module tlb_refill_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_reg = 2'd3;
  logic [31:0] wr_data = '0;
  logic [3:0]  bank = '0;
  logic        f_we = 1'b0;
  logic [31:0] f_cause = '0;
  logic        rd_bank = 1'b0;
  logic [1:0]  rd_way = '0;
  logic [3:0]  rd_set = '0;
  logic [31:0] rd_hi, rd_lo, cause, faddr;
  logic [5:0]  sel;
  logic        fvalid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_hi [2][64];
  logic [31:0] m_lo [2][64];
  logic [31:0] m_cause = '0;
  logic [5:0]  m_sel = '0;
  logic        m_fv = 1'b0;
  logic [31:0] m_fa = '0;

  always #4 clk = ~clk;

  tlb_refill_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_reg_i(wr_reg),
    .wr_data_i(wr_data), .bank_sel_i(bank), .fault_we_i(f_we),
    .fault_cause_i(f_cause), .rd_bank_i(rd_bank), .rd_way_i(rd_way),
    .rd_set_i(rd_set), .rd_hi_o(rd_hi), .rd_lo_o(rd_lo), .sel_o(sel),
    .cause_o(cause), .flush_valid_o(fvalid), .flush_addr_o(faddr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk("R2", {tag, " sel"}, 32'(sel), 32'(m_sel));
    chk("R3/R7", {tag, " cause"}, cause, m_cause);
    chk("R6", {tag, " flush_valid"}, 32'(fvalid), 32'(m_fv));
    if (m_fv) chk("R6", {tag, " flush_addr"}, faddr, m_fa);
    chk("R4/R8", {tag, " rd_hi"}, rd_hi, m_hi[rd_bank][{rd_way, rd_set}]);
    chk("R4/R8", {tag, " rd_lo"}, rd_lo, m_lo[rd_bank][{rd_way, rd_set}]);
  endtask

  // one clock of stimulus, then model update and full comparison
  task automatic step(input string tag, input logic en, input logic [1:0] rg, input logic [31:0] d,
                      input logic [3:0] bk, input logic fu, input logic [31:0] fc,
                      input logic rb, input logic [1:0] rw, input logic [3:0] rs);
    logic ok;
    logic bi;
    logic [31:0] old_cause;
    wr_en = en; wr_reg = rg; wr_data = d; bank = bk;
    f_we = fu; f_cause = fc; rd_bank = rb; rd_way = rw; rd_set = rs;
    @(posedge clk);
    @(negedge clk);
    ok = (bk == 4'd1) || (bk == 4'd2);
    bi = (bk == 4'd2);
    old_cause = m_cause;
    m_fv = 1'b0;
    if (en && rg == 2'd2 && ok) begin
      m_fa = m_hi[bi][m_sel] & 32'hFFFF_E000;
      m_hi[bi][m_sel] = old_cause;
      m_lo[bi][m_sel] = d;
      m_fv = 1'b1;
    end
    if (en && rg == 2'd1 && ok) m_cause = d;
    else if (fu) m_cause = fc;
    if (en && rg == 2'd0) m_sel = d[5:0];
    compare_all(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 64; i++) begin
        m_hi[b][i] = '0;
        m_lo[b][i] = '0;
      end
    #20;
    @(negedge clk);
    // R1 reset state
    chk("R1", "sel after reset", 32'(sel), 0);
    chk("R1", "cause after reset", cause, 0);
    chk("R1", "flush_valid after reset", 32'(fvalid), 0);
    rst_n = 1'b1;
    step("R1 idle", 0, 2'd3, 0, 0, 0, 0, 1, 2'd3, 4'd15);

    // R2 select way 2 set 5, R3 high write, R4 commit in instruction bank
    step("R2 sel", 1, 2'd0, 32'h25, 4'd0, 0, 0, 0, 2'd2, 4'd5);
    step("R3 hi", 1, 2'd1, 32'hAAAA_5123, 4'd1, 0, 0, 0, 2'd2, 4'd5);
    step("R4 lo instr", 1, 2'd2, 32'h0000_1111, 4'd1, 0, 0, 0, 2'd2, 4'd5);
    step("R8 other bank", 0, 2'd3, 0, 0, 0, 0, 1, 2'd2, 4'd5);
    // R4 data bank at the same slot
    step("R3 hi data", 1, 2'd1, 32'h1234_5678, 4'd2, 0, 0, 1, 2'd2, 4'd5);
    step("R4 lo data", 1, 2'd2, 32'h0000_2222, 4'd2, 0, 0, 1, 2'd2, 4'd5);
    step("R8 instr kept", 0, 2'd3, 0, 0, 0, 0, 0, 2'd2, 4'd5);
    // R6 overwrite: flush address from old high word
    step("R3 hi new", 1, 2'd1, 32'h7777_0001, 4'd1, 0, 0, 0, 2'd2, 4'd5);
    step("R6 overwrite", 1, 2'd2, 32'h0000_3333, 4'd1, 0, 0, 0, 2'd2, 4'd5);
    step("R6 pulse ends", 0, 2'd3, 0, 0, 0, 0, 0, 2'd2, 4'd5);
    // R5 bad bank codes
    step("R5 hi bank0", 1, 2'd1, 32'hDEAD_BEEF, 4'd0, 0, 0, 0, 2'd2, 4'd5);
    step("R5 lo bank3", 1, 2'd2, 32'hDEAD_BEEF, 4'd3, 0, 0, 0, 2'd2, 4'd5);
    step("R5 lo bank15", 1, 2'd2, 32'hCAFE_0000, 4'd15, 0, 0, 1, 2'd2, 4'd5);
    // R7 fault alone, then R4 commit using fault cause at way 3 set 15
    step("R7 fault", 0, 2'd3, 0, 0, 1, 32'hFACE_8000, 0, 2'd3, 4'd15);
    step("R2 sel top", 1, 2'd0, 32'hFFFF_FFFF, 4'd0, 0, 0, 0, 2'd3, 4'd15);
    step("R4 lo from fault", 1, 2'd2, 32'h0000_4444, 4'd1, 0, 0, 0, 2'd3, 4'd15);
    // R7 priority
    step("R7 sw wins", 1, 2'd1, 32'h0BAD_F00D, 4'd2, 1, 32'h1111_1111, 0, 2'd3, 4'd15);
    step("R7 fault vs bad hi", 1, 2'd1, 32'h2222_2222, 4'd7, 1, 32'h3333_3333, 0, 2'd3, 4'd15);
    step("R7 fault with commit", 1, 2'd2, 32'h0000_5555, 4'd2, 1, 32'h4444_4444, 1, 2'd3, 4'd15);
    // R6 back-to-back commits
    step("R6 b2b a", 1, 2'd2, 32'h0000_6666, 4'd2, 0, 0, 1, 2'd3, 4'd15);
    step("R6 b2b b", 1, 2'd2, 32'h0000_7777, 4'd2, 0, 0, 1, 2'd3, 4'd15);
    // sweep all ways over a few sets in both banks
    for (int w = 0; w < 4; w++) begin
      for (int s = 0; s < 16; s += 5) begin
        step("R2 sweep sel", 1, 2'd0, 32'({w[1:0], s[3:0]}), 4'd9, 0, 0, 0, w[1:0], s[3:0]);
        step("R3 sweep hi", 1, 2'd1, {w[7:0], s[7:0], 16'hE123}, 4'd1, 0, 0, 0, w[1:0], s[3:0]);
        step("R4 sweep lo", 1, 2'd2, {16'h0, w[7:0], s[7:0]}, 4'(1 + (w % 2)), 0, 0,
             1'(w % 2), w[1:0], s[3:0]);
        step("R8 sweep other", 0, 2'd3, 0, 0, 0, 0, 1'((w + 1) % 2), w[1:0], s[3:0]);
      end
    end
    step("R6 reoverwrite", 1, 2'd2, 32'h0000_8888, 4'd1, 0, 0, 0, 2'd3, 4'd15);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule